// File: doc/BRIEF.md
# DRAM Access Timing Sequencer

This block sits between a processor's bus interface and an array of dynamic RAM organised as up to four banks. When the processor presents an address strobe while the memory is selected, the sequencer drives the row strobe of the addressed bank. It holds the external address multiplexer on the row half for a programmed hold time, then flips it to the column half and drops the column strobe. After a programmed number of wait states it pulses an acknowledge. Column multiplexing itself happens outside the block; the sequencer only supplies the select.

In normal mode the row strobe is released once the access ends and a programmed minimum low time has elapsed. In page mode the row stays open after the access. A later access that hits the open row goes straight to the column phase, using its own wait count, or a third count when the access is flagged as a burst. A miss closes the page and reopens with full row timing. Whether an access hits can come from an internal row comparator or from an external hit input. Every row strobe has its own precharge counter, so after a release only a new access to that same bank waits; an access to another bank proceeds at once.

Top module: `dram_seq`

## Requirements
- R1: An access is accepted only on a clock edge where `ads_i` and `cs_i` are both high. A strobe with `cs_i` low leaves all outputs idle. After reset, `ras_n_o` is all ones, `cas_n_o` is 1, and `mux_col_o` and `ack_o` are 0.
- R2: The bank is `req_addr_i[ROW_W+1:ROW_W]` and drives `ras_n_o[bank]` (active low). When that bank is not precharging, its row strobe is low in the cycle right after the accepting edge. At most one row strobe is low at a time.
- R3: The row strobe stays low with `mux_col_o`=0 for max(1, `t_rah_i`) cycles. Then `mux_col_o` goes to 1 and `cas_n_o` goes low, and both stay so in the acknowledge cycle.
- R4: `ack_o` is a one-cycle pulse. For an opening access it appears max(1,`t_rah_i`)+`ws_open_i` cycles after the accepting edge.
- R5: In normal mode (`page_mode_i`=0) the row strobe stays low for max(L+2, `t_ras_i`+1) cycles, where L is the acknowledge latency of R4. It then returns high.
- R6: After a bank's row strobe returns high, a new access to the same bank waits until that bank's precharge count of `t_rp_i` has run out. With the strobe already present, the bank stays high for `t_rp_i`+1 cycles. An access to a different, idle bank starts one cycle after the release.
- R7: In page mode the row strobe stays low after the acknowledge while `cas_n_o` returns high. A hit is acknowledged `ws_page_i` cycles after the accepting edge, or `ws_burst_i` cycles when `burst_i` is high with the strobe.
- R8: In page mode a miss releases the open row at the accepting edge, so all row strobes are high in the next cycle. It then reopens with full row timing: latency 1+P+max(1,`t_rah_i`)+`ws_open_i`, where P is `t_rp_i` for the same bank and 0 for an idle other bank.
- R9: With `ext_page_sel_i`=1 the hit decision is `ext_page_hit_i` alone, whatever the row compare says.
- R10: Strobes that arrive while an access or a row release is still in progress are ignored. They produce no acknowledge and open no bank.
- R11: Dropping `page_mode_i` while a page is open and no strobe is present closes it: all row strobes are high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ads_i | input | 1 | Address strobe |
| cs_i | input | 1 | Memory select qualifier |
| req_addr_i | input | 2+ROW_W | Bank (upper 2 bits) and row address |
| burst_i | input | 1 | Marks a page hit as a burst beat |
| page_mode_i | input | 1 | 1 = keep row open after access |
| ext_page_sel_i | input | 1 | 1 = use external hit input |
| ext_page_hit_i | input | 1 | External page-hit decision |
| t_rah_i | input | 3 | Row hold cycles (0 treated as 1) |
| t_ras_i | input | 3 | Minimum row strobe low count |
| t_rp_i | input | 3 | Precharge count per bank |
| ws_open_i | input | 3 | Wait states, opening access |
| ws_page_i | input | 3 | Wait states, page hit |
| ws_burst_i | input | 3 | Wait states, burst hit |
| ras_n_o | output | NBANK | Row strobes, active low, one per bank |
| cas_n_o | output | 1 | Column strobe, active low |
| mux_col_o | output | 1 | 1 = column half on DRAM address bus |
| ack_o | output | 1 | One-cycle access-done pulse |

## Verification
The hardest situation to reach is a new access landing on a bank in the very cycle its precharge counter is loaded. A strobe driven after the bench sees the release would already be late. The stimulus instead holds the strobe and select high for the whole preceding access, relying on R10 to have it ignored until the release edge. It then swaps the address to another bank while the strobe is still held. This places the same-bank and other-bank cases exactly on the release cycle, and the high gap of the row strobe can be measured to the cycle.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  localparam int SEQ_CNT_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREWAIT,
    ST_ROW,
    ST_COL,
    ST_HOLD,
    ST_PAGE
  } seq_st_e;

  typedef enum logic [1:0] {
    ACC_OPEN,
    ACC_PAGE,
    ACC_BURST
  } acc_kind_e;

  // cycles the row half stays on the bus; zero is stretched to one
  function automatic logic [SEQ_CNT_W-1:0] row_hold_len(input logic [SEQ_CNT_W-1:0] rah);
    return (rah == '0) ? SEQ_CNT_W'(1) : rah;
  endfunction

  // wait-state count for the column phase of a given access kind
  function automatic logic [SEQ_CNT_W-1:0] wait_len(input acc_kind_e kind,
                                                    input logic [SEQ_CNT_W-1:0] ws_o,
                                                    input logic [SEQ_CNT_W-1:0] ws_p,
                                                    input logic [SEQ_CNT_W-1:0] ws_b);
    case (kind)
      ACC_PAGE:  return ws_p;
      ACC_BURST: return ws_b;
      default:   return ws_o;
    endcase
  endfunction

  // page hit: external decision overrides the row compare when selected
  function automatic logic hit_decide(input logic ext_sel, input logic ext_hit,
                                      input logic same_row);
    return ext_sel ? ext_hit : same_row;
  endfunction

endpackage

// File: rtl/dram_seq_prech.sv
module dram_seq_prech #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);

  AST_PRE_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && len_i != '0) |=> busy_o); // R6

endmodule

// File: rtl/dram_seq_page_det.sv
module dram_seq_page_det #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              ext_sel_i,
  input  logic              ext_hit_i,
  output logic              hit_o,
  output logic [BANK_W-1:0] open_bank_o
);
  import dram_seq_pkg::*;

  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic              same_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
    end else if (ld_i) begin
      bank_q <= bank_i;
      row_q  <= row_i;
    end
  end

  assign same_row    = (bank_i == bank_q) && (row_i == row_q);
  assign hit_o       = hit_decide(ext_sel_i, ext_hit_i, same_row);
  assign open_bank_o = bank_q;

  AST_OPEN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (open_bank_o == $past(bank_i))); // R2

endmodule

// File: rtl/dram_seq.sv
module dram_seq #(
  parameter int ROW_W = 8,
  parameter int NBANK = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ads_i,
  input  logic                              cs_i,
  input  logic [$clog2(NBANK)+ROW_W-1:0]    req_addr_i,
  input  logic                              burst_i,
  input  logic                              page_mode_i,
  input  logic                              ext_page_sel_i,
  input  logic                              ext_page_hit_i,
  input  logic [dram_seq_pkg::SEQ_CNT_W-1:0] t_rah_i,
  input  logic [dram_seq_pkg::SEQ_CNT_W-1:0] t_ras_i,
  input  logic [dram_seq_pkg::SEQ_CNT_W-1:0] t_rp_i,
  input  logic [dram_seq_pkg::SEQ_CNT_W-1:0] ws_open_i,
  input  logic [dram_seq_pkg::SEQ_CNT_W-1:0] ws_page_i,
  input  logic [dram_seq_pkg::SEQ_CNT_W-1:0] ws_burst_i,
  output logic [NBANK-1:0]                  ras_n_o,
  output logic                              cas_n_o,
  output logic                              mux_col_o,
  output logic                              ack_o
);
  import dram_seq_pkg::*;

  localparam int BANK_W = $clog2(NBANK);
  localparam int CNT_W  = SEQ_CNT_W;

  seq_st_e           st_q, st_d;
  logic [CNT_W-1:0]  rcnt_q, rcnt_d;
  logic [CNT_W-1:0]  rascnt_q, rascnt_d;

  // named internal events
  logic              strobe;
  logic              accept_open;
  logic              release_ev;
  logic              enter_row;
  logic              page_hit;
  logic              ras_act;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [BANK_W-1:0] open_bank;
  logic [NBANK-1:0]  pre_busy;

  assign strobe   = ads_i & cs_i;
  assign req_bank = req_addr_i[ROW_W +: BANK_W];
  assign req_row  = req_addr_i[ROW_W-1:0];

  dram_seq_page_det #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_page (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_i       (accept_open),
    .bank_i     (req_bank),
    .row_i      (req_row),
    .ext_sel_i  (ext_page_sel_i),
    .ext_hit_i  (ext_page_hit_i),
    .hit_o      (page_hit),
    .open_bank_o(open_bank)
  );

  always_comb begin
    st_d        = st_q;
    rcnt_d      = rcnt_q;
    accept_open = 1'b0;
    release_ev  = 1'b0;
    enter_row   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (strobe) begin
          accept_open = 1'b1;
          if (pre_busy[req_bank]) st_d = ST_PREWAIT;
          else                    enter_row = 1'b1;
        end
      end
      ST_PREWAIT: begin
        if (!pre_busy[open_bank]) enter_row = 1'b1;
      end
      ST_ROW: begin
        if (rcnt_q <= CNT_W'(1)) begin
          st_d   = ST_COL;
          rcnt_d = wait_len(ACC_OPEN, ws_open_i, ws_page_i, ws_burst_i);
        end else begin
          rcnt_d = rcnt_q - CNT_W'(1);
        end
      end
      ST_COL: begin
        if (rcnt_q == '0) st_d = page_mode_i ? ST_PAGE : ST_HOLD;
        else              rcnt_d = rcnt_q - CNT_W'(1);
      end
      ST_HOLD: begin
        if (rascnt_q == '0) begin
          st_d       = ST_IDLE;
          release_ev = 1'b1;
        end
      end
      ST_PAGE: begin
        if (strobe) begin
          if (page_mode_i && page_hit) begin
            st_d   = ST_COL;
            rcnt_d = wait_len(burst_i ? ACC_BURST : ACC_PAGE,
                              ws_open_i, ws_page_i, ws_burst_i);
          end else begin
            st_d        = ST_PREWAIT;
            accept_open = 1'b1;
            release_ev  = 1'b1;
          end
        end else if (!page_mode_i) begin
          st_d       = ST_IDLE;
          release_ev = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (enter_row) begin
      st_d   = ST_ROW;
      rcnt_d = row_hold_len(t_rah_i);
    end
    if (enter_row)              rascnt_d = t_ras_i;
    else if (rascnt_q != '0)    rascnt_d = rascnt_q - CNT_W'(1);
    else                        rascnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rcnt_q   <= '0;
      rascnt_q <= '0;
    end else begin
      st_q     <= st_d;
      rcnt_q   <= rcnt_d;
      rascnt_q <= rascnt_d;
    end
  end

  assign ras_act   = (st_q == ST_ROW) || (st_q == ST_COL) ||
                     (st_q == ST_HOLD) || (st_q == ST_PAGE);
  assign cas_n_o   = (st_q != ST_COL);
  assign mux_col_o = (st_q == ST_COL);
  assign ack_o     = (st_q == ST_COL) && (rcnt_q == '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dram_seq_prech #(.CNT_W(CNT_W)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(release_ev && (open_bank == BANK_W'(b))),
      .len_i (t_rp_i),
      .busy_o(pre_busy[b])
    );
    assign ras_n_o[b] = !(ras_act && (open_bank == BANK_W'(b)));

    AST_PRE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      pre_busy[b] |-> ras_n_o[b]); // R6
  end

  AST_RAS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ras_n_o)); // R2
  AST_RAS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && strobe && !pre_busy[req_bank]) |=> !ras_n_o[$past(req_bank)]); // R2
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n_o |-> ($countones(~ras_n_o) == 1)); // R3
  AST_ACK_ON_COL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (!cas_n_o && mux_col_o)); // R4
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o); // R4
  AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !page_mode_i) |=> (cas_n_o && $countones(~ras_n_o) == 1)); // R5
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ROW || st_q == ST_COL || st_q == ST_HOLD || st_q == ST_PREWAIT) && strobe)
      |=> $stable(open_bank)); // R10

endmodule

// File: tb/dram_seq_tb_top.sv
`timescale 1ns/1ps
module dram_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ads = 1'b0, cs = 1'b0, burst = 1'b0;
  logic       pmode = 1'b0, esel = 1'b0, ehit = 1'b0;
  logic [2:0] rah = 3'd1, ras = 3'd0, rp = 3'd0;
  logic [2:0] wso = 3'd0, wsp = 3'd0, wsb = 3'd0;
  logic [9:0] addr = '0;
  logic [3:0] ras_n;
  logic       cas_n, mux, ack;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ads_i(ads), .cs_i(cs), .req_addr_i(addr),
    .burst_i(burst), .page_mode_i(pmode), .ext_page_sel_i(esel),
    .ext_page_hit_i(ehit), .t_rah_i(rah), .t_ras_i(ras), .t_rp_i(rp),
    .ws_open_i(wso), .ws_page_i(wsp), .ws_burst_i(wsb),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .mux_col_o(mux), .ack_o(ack)
  );

  // {rah, ws_open, t_ras, t_rp}
  localparam logic [11:0] VEC [8] = '{
    {3'd2, 3'd1, 3'd3, 3'd2}, {3'd0, 3'd0, 3'd0, 3'd0},
    {3'd1, 3'd2, 3'd7, 3'd1}, {3'd3, 3'd3, 3'd2, 3'd3},
    {3'd7, 3'd0, 3'd5, 3'd7}, {3'd1, 3'd7, 3'd1, 3'd4},
    {3'd4, 3'd4, 3'd7, 3'd0}, {3'd2, 3'd0, 3'd7, 3'd5}
  };

  function automatic logic [9:0] mk(input int b, input int r);
    return {2'(b), 8'(r)};
  endfunction

  function automatic int hold_of(input int r);
    return (r == 0) ? 1 : r;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(input logic [9:0] a, input logic bu, input bit wait_rel,
                        output int lat, output int low, output int row,
                        output logic [3:0] ras0, output int acks, output int casmux);
    int n;
    bit got;
    int b;
    b = int'(a[9:8]);
    @(negedge clk); ads = 1'b1; cs = 1'b1; addr = a; burst = bu;
    @(negedge clk); ads = 1'b0; cs = 1'b0; burst = 1'b0;
    ras0 = ras_n; n = 0; got = 0; lat = -1; low = 0; row = 0; acks = 0; casmux = 0;
    while (n < 300) begin
      if (!ras_n[b]) low++;
      if (!got && !ras_n[b] && !mux) row++;
      if (ack) begin
        acks++;
        casmux = (!cas_n && mux) ? 1 : 0;
        if (!got) begin got = 1; lat = n; end
      end
      if (got && (!wait_rel || ras_n[b])) break;
      @(negedge clk); n++;
    end
  endtask

  task automatic wait_idle();
    int g = 0;
    while (ras_n != 4'hF && g < 500) begin @(negedge clk); g++; end
    repeat (10) @(negedge clk);
  endtask

  task automatic measure_gap(output int gap);
    int g = 0;
    while (ras_n == 4'hF && g < 200) begin @(negedge clk); g++; end
    while (ras_n != 4'hF && g < 200) begin @(negedge clk); g++; end
    gap = 0;
    while (ras_n == 4'hF && g < 200) begin gap++; @(negedge clk); g++; end
  endtask

  initial begin
    int lat, low, row, acks, cm, gap, b;
    logic [3:0] r0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset ras_n", int'(ras_n), 15);
    chk("R1 reset cas_n", int'(cas_n), 1);
    chk("R1 reset mux", int'(mux), 0);
    chk("R1 reset ack", int'(ack), 0);

    // R1 strobe without select is ignored
    ads = 1'b1; cs = 1'b0; addr = mk(1, 4);
    repeat (3) @(negedge clk);
    ads = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        if (ras_n != 4'hF || ack) seen++;
        @(negedge clk);
      end
      chk("R1 no access without cs", seen, 0);
    end

    // table of normal-mode openings: R2 R3 R4 R5
    pmode = 1'b0;
    for (int i = 0; i < 8; i++) begin
      rah = VEC[i][11:9]; wso = VEC[i][8:6]; ras = VEC[i][5:3]; rp = VEC[i][2:0];
      b = i % 4;
      access(mk(b, i * 3 + 1), 1'b0, 1'b1, lat, low, row, r0, acks, cm);
      chk("R2 first-cycle ras", int'(r0), int'(~(4'b1 << b) & 4'hF));
      chk("R3 row-hold cycles", row, hold_of(int'(rah)));
      chk("R3 cas/mux at ack", cm, 1);
      chk("R4 opening latency", lat, hold_of(int'(rah)) + int'(wso));
      chk("R4 single ack", acks, 1);
      chk("R5 ras low cycles", low,
          max2(hold_of(int'(rah)) + int'(wso) + 2, int'(ras) + 1));
      wait_idle();
    end

    // R10 strobes during a busy access are ignored
    rah = 3'd1; wso = 3'd4; ras = 3'd0; rp = 3'd0;
    @(negedge clk); ads = 1'b1; cs = 1'b1; addr = mk(0, 1);
    @(negedge clk); ads = 1'b0; cs = 1'b0;
    begin
      int ac = 0, b3 = 0;
      for (int n = 0; n < 25; n++) begin
        if (n == 2) begin ads = 1'b1; cs = 1'b1; addr = mk(3, 2); end
        if (n == 4) begin ads = 1'b0; cs = 1'b0; end
        if (ack) ac++;
        if (!ras_n[3]) b3++;
        @(negedge clk);
      end
      chk("R10 one ack only", ac, 1);
      chk("R10 other bank never opened", b3, 0);
    end
    wait_idle();

    // R6 precharge per bank, strobe held across release
    rah = 3'd1; wso = 3'd0; ras = 3'd0; rp = 3'd4;
    @(negedge clk); ads = 1'b1; cs = 1'b1; addr = mk(0, 7);
    measure_gap(gap);
    chk("R6 same-bank high gap", gap, 5);
    addr = mk(3, 7);
    measure_gap(gap);
    chk("R6 other-bank high gap", gap, 1);
    ads = 1'b0; cs = 1'b0;
    wait_idle();

    // page mode: R7 R8 R9 R11
    pmode = 1'b1; rah = 3'd2; wso = 3'd1; wsp = 3'd2; wsb = 3'd0; rp = 3'd3; ras = 3'd5;
    access(mk(1, 5), 1'b0, 1'b0, lat, low, row, r0, acks, cm);
    chk("R4 page opening latency", lat, 3);
    @(negedge clk);
    chk("R7 ras held after ack", int'(ras_n), 13);
    chk("R7 cas high after ack", int'(cas_n), 1);
    chk("R4 ack pulse ends", int'(ack), 0);
    access(mk(1, 5), 1'b0, 1'b0, lat, low, row, r0, acks, cm);
    chk("R7 page hit latency", lat, 2);
    chk("R7 ras low on hit start", int'(r0), 13);
    access(mk(1, 5), 1'b1, 1'b0, lat, low, row, r0, acks, cm);
    chk("R7 burst hit latency", lat, 0);
    access(mk(2, 5), 1'b0, 1'b0, lat, low, row, r0, acks, cm);
    chk("R8 miss releases all", int'(r0), 15);
    chk("R8 miss other bank latency", lat, 4);
    access(mk(2, 9), 1'b0, 1'b0, lat, low, row, r0, acks, cm);
    chk("R8 miss same bank latency", lat, 7);
    esel = 1'b1; ehit = 1'b1;
    access(mk(2, 12), 1'b0, 1'b0, lat, low, row, r0, acks, cm);
    chk("R9 external hit on other row", lat, 2);
    ehit = 1'b0;
    access(mk(2, 9), 1'b0, 1'b0, lat, low, row, r0, acks, cm);
    chk("R9 external miss on same row", lat, 7);
    esel = 1'b0;
    @(negedge clk); pmode = 1'b0;
    @(negedge clk);
    chk("R11 page closes", int'(ras_n), 15);
    wait_idle();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule